// File: doc/BRIEF.md
# Paged Nonvolatile Byte Store Controller

This block models a byte-wide nonvolatile store of 8192 locations behind a parallel bus. The bus has active-low chip select, output enable and write enable, a 13-bit address, and an 8-bit data path split into an input, an output and an output-enable. Reads return stored bytes. Writes are gathered into a 32-byte staging buffer. Once the host has stopped loading bytes for a programmable window, a self-timed programming cycle moves the staged bytes into the store.

The low five address bits choose the byte within a page. The upper bits choose the page, and that page is fixed by the first byte staged. While programming runs, the block reports busy in three ways. A ready output is held low. A read returns the inverse of the top bit of the last staged byte. The next bit flips from one read to the next. Write strobes arriving during that time are dropped. The loading window and the programming time are clock counts, so they can be set to the real timings or shrunk for simulation.

Top module: `nvm_page_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `ready` is 1, nothing is staged, and `data_oe` is 0 while the bus is deselected.
- R2: `data_oe` is 1 exactly when `ce_n`=0, `oe_n`=0 and `we_n`=1. Whenever `data_oe` is 0, `data_out` is 0.
- R3: A write strobe is the first clock in which `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold after a clock in which they did not. Address and data are captured in that clock only, and either `ce_n` or `we_n` may be the signal that completes the condition.
- R4: No write is taken while `ce_n`=1, or while `oe_n`=0.
- R5: `ready` falls exactly `LOAD_CYC` clocks after the last accepted strobe. Each accepted strobe restarts that count.
- R6: The page (address bits 12..5) is taken from the first staged byte. A strobe to another page during loading is dropped and does not restart the window.
- R7: `ready` stays low for exactly `PROG_CYC` clocks (`PROG_CYC` >= 32), and strobes in that time are dropped.
- R8: Once `ready` returns to 1, every staged offset reads back its last staged value. Offsets that were not staged keep their old contents.
- R9: A read while `ready`=0 returns bit 7 as the inverse of bit 7 of the last staged byte, and bits 5..0 equal to that byte's bits 5..0.
- R10: While `ready`=0, bit 6 of read data flips at the end of each read, so two successive reads differ in bit 6. It does not change while `ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 13 | Byte address |
| data_in | input | 8 | Write data from host |
| data_out | output | 8 | Read data or busy status |
| data_oe | output | 1 | Drive enable for `data_out` |
| ready | output | 1 | High when no programming cycle runs |

## Verification
A wrong loading counter or state register shows first on `ready`, in the exact clock it falls or rises. It therefore appears within one window of the faulty value. A wrong page latch or staging slot stays hidden until programming ends. It then shows as a wrong byte on the first read of the affected address. A wrong status register shows on the very next read made while busy, either as an inverted bit 7 or as a bit 6 that fails to alternate.

// File: rtl/nvm_pkg.sv
// Shared types for the paged nonvolatile store controller.
package nvm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } nvm_state_e;
endpackage

// File: rtl/nvm_bus_decode.sv
// Decodes the active-low bus controls into a one-clock write strobe, a read
// level and a read-end pulse. Assumes the controls are synchronous to clk.
module nvm_bus_decode (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic wr_stb,
    output logic rd_act,
    output logic rd_end
);
    logic wr_act;
    logic wr_q;
    logic rd_q;

    assign wr_act = ~ce_n & ~we_n & oe_n;
    assign rd_act = ~ce_n & ~oe_n & we_n;

    // Remember last clock's bus mode for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
        end else begin
            wr_q <= wr_act;
            rd_q <= rd_act;
        end
    end

    assign wr_stb = wr_act & ~wr_q;
    assign rd_end = rd_q & ~rd_act;

    // R3: a held write produces one strobe only
    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);
endmodule

// File: rtl/nvm_page_buf.sv
// Staging buffer for one page: byte slots with valid flags, the page number
// latched from the first staged byte, and the last staged byte for status.
// Assumes load_i and clear_i are never raised in the same clock.
module nvm_page_buf #(
    parameter int DW    = 8,
    parameter int OFF_W = 5,
    parameter int PG_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [PG_W-1:0]  page_i,
    input  logic [DW-1:0]    din_i,
    input  logic             clear_i,
    input  logic [OFF_W-1:0] idx_i,
    output logic [DW-1:0]    idx_data_o,
    output logic             idx_valid_o,
    output logic [PG_W-1:0]  page_o,
    output logic             any_o,
    output logic [DW-1:0]    last_o
);
    localparam int DEPTH = 1 << OFF_W;

    logic [DW-1:0]    slot_q [DEPTH];
    logic [DEPTH-1:0] valid_q;
    logic [PG_W-1:0]  page_q;
    logic [DW-1:0]    last_q;

    // Byte slots: no reset, only read where the valid flag is set.
    always_ff @(posedge clk) begin
        if (load_i) slot_q[off_i] <= din_i;
    end

    // Valid flags: set on load, cleared when a page is committed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) valid_q <= '0;
        else if (load_i)       valid_q[off_i] <= 1'b1;
    end

    // Page latch from the first byte, and the last-byte record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
            last_q <= '0;
        end else if (load_i) begin
            last_q <= din_i;
            if (!any_o) page_q <= page_i;
        end
    end

    assign any_o       = |valid_q;
    assign page_o      = page_q;
    assign last_o      = last_q;
    assign idx_data_o  = slot_q[idx_i];
    assign idx_valid_o = valid_q[idx_i];

    // R6: the page number does not move once a page is open
    assert_page_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && any_o) |=> $stable(page_o));
endmodule

// File: rtl/nvm_store.sv
// Byte array with one synchronous write port and one combinational read port.
// Contents are not reset, as in a real nonvolatile array.
module nvm_store #(
    parameter int AW = 13,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cell_q [DEPTH];

    // Write port driven by the commit sequencer.
    always_ff @(posedge clk) begin
        if (we_i) cell_q[waddr_i] <= wdata_i;
    end

    assign rdata_o = cell_q[raddr_i];

    // R8: commit writes always carry a defined address
    assert_commit_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> !$isunknown(waddr_i));
endmodule

// File: rtl/nvm_page_ctrl.sv
// Top of the paged nonvolatile store. The block stages bus writes into a page
// buffer and ends loading after LOAD_CYC quiet clocks. It then programs for
// PROG_CYC clocks, committing one slot per clock, and reports busy status on
// reads and on ready. Assumes PROG_CYC >= 2**OFF_W and synchronous controls.
module nvm_page_ctrl #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int OFF_W    = 5,
    parameter int LOAD_CYC = 5000,
    parameter int PROG_CYC = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data_in,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              ready
);
    import nvm_pkg::*;

    localparam int PG_W = ADDR_W - OFF_W;
    localparam int LT_W = $clog2(LOAD_CYC + 1);
    localparam int PT_W = $clog2(PROG_CYC + 1);
    localparam int IX_W = OFF_W + 1;

    nvm_state_e        state_q;
    logic [LT_W-1:0]   lt_q;
    logic [PT_W-1:0]   pt_q;
    logic [IX_W-1:0]   ix_q;
    logic              tog_q;

    logic              wr_stb, rd_act, rd_end;
    logic              accept, prog, clear, commit_we;
    logic [PG_W-1:0]   page_cur;
    logic              buf_any, idx_valid;
    logic [DATA_W-1:0] idx_data, last_byte, mem_rdata;

    nvm_bus_decode u_dec (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .wr_stb(wr_stb), .rd_act(rd_act), .rd_end(rd_end)
    );

    assign prog   = (state_q == ST_PROG);
    assign accept = wr_stb && ((state_q == ST_IDLE) ||
                    ((state_q == ST_LOAD) && (addr[ADDR_W-1:OFF_W] == page_cur)));
    assign clear  = prog && (pt_q == PT_W'(1));

    nvm_page_buf #(.DW(DATA_W), .OFF_W(OFF_W), .PG_W(PG_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .load_i(accept),
        .off_i(addr[OFF_W-1:0]), .page_i(addr[ADDR_W-1:OFF_W]), .din_i(data_in),
        .clear_i(clear), .idx_i(ix_q[OFF_W-1:0]),
        .idx_data_o(idx_data), .idx_valid_o(idx_valid),
        .page_o(page_cur), .any_o(buf_any), .last_o(last_byte)
    );

    assign commit_we = prog && !ix_q[OFF_W] && idx_valid;

    nvm_store #(.AW(ADDR_W), .DW(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we_i(commit_we),
        .waddr_i({page_cur, ix_q[OFF_W-1:0]}), .wdata_i(idx_data),
        .raddr_i(addr), .rdata_o(mem_rdata)
    );

    // Sequencer: idle, page loading with restartable window, timed program.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lt_q    <= '0;
            pt_q    <= '0;
            ix_q    <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_LOAD;
                        lt_q    <= LT_W'(LOAD_CYC);
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        lt_q <= LT_W'(LOAD_CYC);
                    end else if (lt_q == LT_W'(1)) begin
                        state_q <= ST_PROG;
                        pt_q    <= PT_W'(PROG_CYC);
                        ix_q    <= '0;
                    end else begin
                        lt_q <= lt_q - 1'b1;
                    end
                end
                ST_PROG: begin
                    if (!ix_q[OFF_W]) ix_q <= ix_q + 1'b1;
                    if (pt_q == PT_W'(1)) state_q <= ST_IDLE;
                    else                  pt_q    <= pt_q - 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Toggle status: flips at the end of each read made while programming.
    always_ff @(posedge clk) begin
        if (!rst_n)              tog_q <= 1'b0;
        else if (prog && rd_end) tog_q <= ~tog_q;
    end

    // Read mux: busy status while programming, stored byte otherwise.
    always_comb begin
        data_out = '0;
        if (rd_act) begin
            if (prog) begin
                data_out           = last_byte;
                data_out[DATA_W-1] = ~last_byte[DATA_W-1];
                data_out[DATA_W-2] = tog_q;
            end else begin
                data_out = mem_rdata;
            end
        end
    end

    assign data_oe = rd_act;
    assign ready   = ~prog;

    // Checker counter: length of the current busy stretch.
    logic [PT_W:0] busy_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (prog) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    // R7: busy lasts exactly the programming count
    assert_busy_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog) |-> (busy_cnt == (PT_W+1)'(PROG_CYC)));
    // R5: programming is only entered from page loading
    assert_enter_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog) |-> ($past(state_q) == ST_LOAD));
    // R9: the status byte source is frozen while programming
    assert_status_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> $stable(last_byte));
    // R10: the toggle bit holds while not programming
    assert_tog_still_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !prog |=> $stable(tog_q));
    // R4: a deselected bus neither drives nor loads
    assert_deselect_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (!data_oe && !accept));
endmodule

// File: tb/nvm_page_ctrl_test.sv
// Bench: behavioural reference model compared every clock, plus directed checks.
module nvm_page_ctrl_test;
    localparam int LC = 8;
    localparam int PC = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  data_in = '0;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        ready;

    int checks = 0;
    int errors = 0;

    nvm_page_ctrl #(.LOAD_CYC(LC), .PROG_CYC(PC)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_in), .data_out(data_out),
        .data_oe(data_oe), .ready(ready)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference model state
    logic [7:0] m_mem [int];
    logic [7:0] m_buf [int];
    bit  m_load, m_busy, m_tog, m_pwr, m_prd;
    int  m_lt, m_pt, m_page;
    logic [7:0] m_last;

    always @(posedge clk) begin
        bit wr, rd, stb, rend;
        if (!rst_n) begin
            m_load = 0; m_busy = 0; m_tog = 0; m_pwr = 0; m_prd = 0;
            m_lt = 0; m_pt = 0; m_page = 0; m_last = 0; m_buf.delete();
        end else begin
            wr   = !ce_n && !we_n && oe_n;
            rd   = !ce_n && !oe_n && we_n;
            stb  = wr && !m_pwr;
            rend = m_prd && !rd;
            if (m_busy) begin
                if (rend) m_tog = !m_tog;
                if (m_pt == 1) begin
                    foreach (m_buf[k]) m_mem[m_page * 32 + k] = m_buf[k];
                    m_buf.delete();
                    m_busy = 0;
                end else m_pt--;
            end else if (stb && (!m_load || m_page == int'(addr >> 5))) begin
                if (!m_load) m_page = int'(addr >> 5);
                m_buf[int'(addr & 13'h1f)] = data_in;
                m_last = data_in;
                m_load = 1;
                m_lt = LC;
            end else if (m_load) begin
                if (m_lt == 1) begin m_load = 0; m_busy = 1; m_pt = PC; end
                else m_lt--;
            end
            m_pwr = wr;
            m_prd = rd;
        end
    end

    // Per-clock comparison against the model, away from the edges.
    initial begin
        forever begin
            @(posedge clk); #5;
            if (rst_n) begin
                bit eo;
                logic [7:0] ex;
                eo = !ce_n && !oe_n && we_n;
                check(ready == !m_busy, "R5/R7 ready timing", ready, !m_busy);
                check(data_oe == eo, "R2 drive enable", data_oe, eo);
                if (!eo) check(data_out == 8'h00, "R2 idle data", data_out, 0);
                else if (m_busy) begin
                    ex = {~m_last[7], m_tog, m_last[5:0]};
                    check(data_out == ex, "R9 status read", data_out, ex);
                end else if (m_mem.exists(int'(addr))) begin
                    ex = m_mem[int'(addr)];
                    check(data_out == ex, "R8 stored read", data_out, ex);
                end
            end
        end
    end

    task automatic bus_idle();
        @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1;
    endtask

    task automatic wr_by_we(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = a; data_in = d;
        @(negedge clk); we_n = 0;
        @(negedge clk); we_n = 1;
        @(negedge clk); ce_n = 1;
    endtask

    task automatic wr_by_ce(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk); ce_n = 1; oe_n = 1; we_n = 0; addr = a; data_in = d;
        @(negedge clk); ce_n = 0;
        @(negedge clk); ce_n = 1;
        @(negedge clk); we_n = 1;
    endtask

    task automatic rd(input logic [12:0] a, output logic [7:0] d);
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; addr = a;
        @(posedge clk); #5; d = data_out;
        @(negedge clk); ce_n = 1; oe_n = 1;
    endtask

    task automatic wait_busy();
        for (int i = 0; i < 200 && ready; i++) @(negedge clk);
    endtask

    task automatic wait_done();
        wait_busy();
        for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog (R5/R7): actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d1, d2;
        int n;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(posedge clk); #5;
        check(ready == 1'b1, "R1 ready after reset", ready, 1);
        check(data_oe == 1'b0, "R1 no drive after reset", data_oe, 0);

        // R3/R5: held strobe with changing data, timed loading window
        @(negedge clk); ce_n = 0; oe_n = 1; we_n = 1; addr = 13'h0043; data_in = 8'hA5;
        @(negedge clk); we_n = 0;
        n = 0;
        while (ready && n < 100) begin
            @(negedge clk); n++;
            if (n == 2) data_in = 8'h5A;
            if (n == 3) we_n = 1;
            if (n == 4) ce_n = 1;
        end
        check(n == LC + 1, "R5 window length", n, LC + 1);

        // R9/R10: status reads while busy
        rd(13'h0043, d1);
        rd(13'h0043, d2);
        check(d1[7] == 1'b0, "R9 inverted top bit", d1[7], 0);
        check(d1[5:0] == 6'h25, "R9 low bits", d1[5:0], 6'h25);
        check(d1[6] != d2[6], "R10 toggle differs", d2[6], !d1[6]);
        wait_done();
        rd(13'h0043, d1);
        check(d1 == 8'hA5, "R3 first-clock capture", d1, 8'hA5);

        // R6/R8: page write, stray other-page byte, overwrite
        wr_by_we(13'h00C3, 8'h11);
        wait_done();
        wr_by_ce(13'h00A0, 8'h01);
        wr_by_ce(13'h00A1, 8'h02);
        wr_by_ce(13'h00BF, 8'h03);
        wr_by_ce(13'h00C3, 8'h99);
        wr_by_ce(13'h00A1, 8'h22);
        wait_done();
        rd(13'h00A0, d1); check(d1 == 8'h01, "R8 slot 0", d1, 8'h01);
        rd(13'h00A1, d1); check(d1 == 8'h22, "R8 overwrite", d1, 8'h22);
        rd(13'h00BF, d1); check(d1 == 8'h03, "R8 last slot", d1, 8'h03);
        rd(13'h00C3, d1); check(d1 == 8'h11, "R6 other page ignored", d1, 8'h11);
        rd(13'h0043, d1); check(d1 == 8'hA5, "R8 untouched byte", d1, 8'hA5);

        // R4: writes with oe low or ce high are inhibited
        @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; addr = 13'h0043; data_in = 8'hFF;
        repeat (3) @(negedge clk);
        ce_n = 1; oe_n = 1;
        @(negedge clk); we_n = 1;
        @(negedge clk); we_n = 0;
        @(negedge clk); we_n = 1;
        repeat (LC + 4) @(negedge clk);
        check(ready == 1'b1, "R4 no program started", ready, 1);
        rd(13'h0043, d1); check(d1 == 8'hA5, "R4 byte unchanged", d1, 8'hA5);

        // R7: strobes while busy are dropped
        wr_by_we(13'h0010, 8'h77);
        wait_busy();
        wr_by_we(13'h0043, 8'h00);
        for (int i = 0; i < 200 && !ready; i++) @(negedge clk);
        repeat (LC + 4) @(negedge clk);
        check(ready == 1'b1, "R7 no second program", ready, 1);
        rd(13'h0043, d1); check(d1 == 8'hA5, "R7 busy write dropped", d1, 8'hA5);
        rd(13'h0010, d1); check(d1 == 8'h77, "R8 committed byte", d1, 8'h77);

        bus_idle();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule